// File: doc/BRIEF.md
# Multi-port test mode controller

This block holds the line-test setting of each port of a small USB 2.0 host port register set. It decides in hardware whether a requested test mode may take effect, and it then drives a per-port line-state command toward the transceiver side. A port is allowed into test mode only under four conditions. The controller must own the port: the global configure flag is one and the port's owner bit is zero. Both schedules must be switched off and must also report idle. No other port may already be in test mode. A request that breaks any of these rules is refused and recorded in a sticky error bit, so the undefined case of two ports in test at once never reaches the lines.

Software writes a 4-bit code to a port's address to choose a mode, and writes zero to leave it. The block also pulls a port out of test mode by itself if ownership is lost while the test runs. Entering the packet mode or the force-enable mode also gives a single-cycle start pulse to the external packet or enable logic. The level command stays up for as long as the mode is held.

Top module: `usb_port_test_ctrl`

## Requirements
- R1: After reset every port's drive command is idle (0), all test-active flags and start pulses are 0, and the error bit is 0.
- R2: A write to address p (0 to NUM_PORTS-1) selects a mode for port p with the codes 1 = drive J, 2 = drive K, 3 = SE0 with NAK, 4 = test packet and 5 = force enable. The 3-bit drive command of port p sits at bits 3p+2..3p and equals the accepted code after the next clock edge. The port's test-active flag is 1 exactly while its command is not idle.
- R3: A nonzero code is refused unless the configure flag is 1 and that port's owner bit is 0.
- R4: A nonzero code is refused while any of the periodic enable, asynchronous enable, periodic busy or asynchronous busy inputs is 1.
- R5: A nonzero code for a port is refused while a different port is in test mode, so at most one port is ever active. The port that is already active may be switched to another valid mode.
- R6: Codes 6 to 15 are reserved, and writing one of them is refused.
- R7: A refused write leaves the port's command unchanged and sets the error bit after the next edge. The error bit stays set until a write to address NUM_PORTS has data bit 0 equal to 1, which clears it after the next edge. The same write with data bit 0 equal to 0 has no effect.
- R8: Writing 0 to a port is always accepted and never sets the error bit. The command of an active port returns to idle after the next edge, and the exclusivity lock is released, so another port can then enter.
- R9: If a port is active and either the configure flag is 0 or that port's owner bit is 1, the port is forced back to idle at the next clock edge without any write. This forced exit wins over a write to that port in the same cycle.
- R10: An accepted write of code 4 or 5 that differs from the port's stored code makes that port's start pulse 1 for exactly one cycle, beginning after the write's edge. Codes 1 to 3, repeated codes and forced exits give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NUM_PORTS+1) | Port index, or NUM_PORTS for the error bit |
| wr_data | input | 4 | Test code, or bit 0 = clear error |
| cfg_flag | input | 1 | Global configure flag |
| port_owner | input | NUM_PORTS | Owner bit per port, 0 = owned by this controller |
| per_sched_en | input | 1 | Periodic schedule enable |
| async_sched_en | input | 1 | Asynchronous schedule enable |
| per_sched_busy | input | 1 | Periodic schedule status, 1 = still running |
| async_sched_busy | input | 1 | Asynchronous schedule status, 1 = still running |
| drive_cmd | output | 3*NUM_PORTS | Line-state command per port |
| test_active | output | NUM_PORTS | Port is in test mode |
| start_pulse | output | NUM_PORTS | One-cycle start for packet or force-enable |
| test_err | output | 1 | Sticky refused-request flag |

## Verification
Each result of this block is due one clock edge after its cause. A write changes the drive command, the active flag, the error bit and the start pulse at the following edge. A loss of ownership clears the port at the following edge. The bench drives every write and ownership change half a period before an edge. For that same cycle it pushes the expected state of all outputs into a queue. A monitor pops exactly one item a quarter period after each edge, so each comparison lines up with the one register on the path. Since the start pulse lasts only one cycle, the monitor also confirms that it has dropped in the cycle after.

// File: rtl/usb_ptest_pkg.sv
package usb_ptest_pkg;

  localparam int CODE_W = 4;
  localparam int CMD_W  = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE     = 3'd0,
    CMD_J        = 3'd1,
    CMD_K        = 3'd2,
    CMD_SE0_NAK  = 3'd3,
    CMD_PACKET   = 3'd4,
    CMD_FORCE_EN = 3'd5
  } line_cmd_e;

  // A nonzero code that names one of the five test modes
  function automatic logic code_is_mode(input logic [CODE_W-1:0] c);
    return (c >= CODE_W'(1)) && (c <= CODE_W'(5));
  endfunction

  // Modes that need a start pulse to the external logic
  function automatic logic code_needs_start(input logic [CODE_W-1:0] c);
    return (c == CODE_W'(4)) || (c == CODE_W'(5));
  endfunction

  function automatic line_cmd_e code_to_cmd(input logic [CODE_W-1:0] c);
    line_cmd_e r;
    case (c)
      CODE_W'(1): r = CMD_J;
      CODE_W'(2): r = CMD_K;
      CODE_W'(3): r = CMD_SE0_NAK;
      CODE_W'(4): r = CMD_PACKET;
      CODE_W'(5): r = CMD_FORCE_EN;
      default:    r = CMD_IDLE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ptest_gate.sv
module ptest_gate
  import usb_ptest_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = $clog2(NUM_PORTS + 1)
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CODE_W-1:0]    wr_data,
  input  logic                 cfg_flag,
  input  logic [NUM_PORTS-1:0] port_owner,
  input  logic                 per_sched_en,
  input  logic                 async_sched_en,
  input  logic                 per_sched_busy,
  input  logic                 async_sched_busy,
  input  logic [NUM_PORTS-1:0] port_active,
  output logic [NUM_PORTS-1:0] port_load,
  output logic                 wr_reject,
  output logic                 err_clear
);

  logic sched_idle;
  logic addr_is_port;
  logic addr_is_err;
  logic exit_req;
  logic mode_ok;
  logic [NUM_PORTS-1:0] sel;
  logic [NUM_PORTS-1:0] owned;
  logic [NUM_PORTS-1:0] other_active;
  logic [NUM_PORTS-1:0] deny;

  assign sched_idle   = !(per_sched_en || async_sched_en || per_sched_busy || async_sched_busy);
  assign addr_is_port = wr_addr < ADDR_W'(NUM_PORTS);
  assign addr_is_err  = wr_addr == ADDR_W'(NUM_PORTS);
  assign exit_req     = wr_data == '0;
  assign mode_ok      = code_is_mode(wr_data);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic [NUM_PORTS-1:0] self_mask;
    assign self_mask       = NUM_PORTS'(1) << g;
    assign sel[g]          = wr_en && addr_is_port && (wr_addr == ADDR_W'(g));
    assign owned[g]        = cfg_flag && !port_owner[g];
    assign other_active[g] = |(port_active & ~self_mask);
    assign port_load[g]    = sel[g] && (exit_req ||
                             (mode_ok && owned[g] && sched_idle && !other_active[g]));
    assign deny[g]         = sel[g] && !port_load[g];
  end

  assign wr_reject = |deny;
  assign err_clear = wr_en && addr_is_err && wr_data[0];

endmodule

// File: rtl/ptest_port.sv
module ptest_port
  import usb_ptest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              force_exit,
  output logic [CMD_W-1:0]  cmd,
  output logic              active,
  output logic              start_pulse
);

  logic [CODE_W-1:0] field_q;
  logic              pulse_q;
  logic              enter_start;

  assign enter_start = load && !force_exit && code_needs_start(code) && (code != field_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= enter_start;
      if (force_exit)
        field_q <= '0;
      else if (load)
        field_q <= code;
    end
  end

  assign cmd         = code_to_cmd(field_q);
  assign active      = field_q != '0;
  assign start_pulse = pulse_q;

  // R9
  force_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_exit |=> !active);

  // R10
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (cmd == CMD_PACKET || cmd == CMD_FORCE_EN));

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse || $past(load));

endmodule

// File: rtl/ptest_err.sv
module ptest_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic err
);

  logic err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (set)
      err_q <= 1'b1;
    else if (clear)
      err_q <= 1'b0;
  end

  assign err = err_q;

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clear) |=> err);

endmodule

// File: rtl/usb_port_test_ctrl.sv
module usb_port_test_ctrl
  import usb_ptest_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int ADDR_W   = $clog2(NUM_PORTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [CODE_W-1:0]          wr_data,
  input  logic                       cfg_flag,
  input  logic [NUM_PORTS-1:0]       port_owner,
  input  logic                       per_sched_en,
  input  logic                       async_sched_en,
  input  logic                       per_sched_busy,
  input  logic                       async_sched_busy,
  output logic [CMD_W*NUM_PORTS-1:0] drive_cmd,
  output logic [NUM_PORTS-1:0]       test_active,
  output logic [NUM_PORTS-1:0]       start_pulse,
  output logic                       test_err
);

  logic [NUM_PORTS-1:0] port_load;
  logic [NUM_PORTS-1:0] force_exit;
  logic                 wr_reject;
  logic                 err_clear;

  ptest_gate #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_gate (
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .cfg_flag        (cfg_flag),
    .port_owner      (port_owner),
    .per_sched_en    (per_sched_en),
    .async_sched_en  (async_sched_en),
    .per_sched_busy  (per_sched_busy),
    .async_sched_busy(async_sched_busy),
    .port_active     (test_active),
    .port_load       (port_load),
    .wr_reject       (wr_reject),
    .err_clear       (err_clear)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign force_exit[g] = test_active[g] && (!cfg_flag || port_owner[g]);

    ptest_port u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (port_load[g]),
      .code       (wr_data),
      .force_exit (force_exit[g]),
      .cmd        (drive_cmd[CMD_W*g +: CMD_W]),
      .active     (test_active[g]),
      .start_pulse(start_pulse[g])
    );

    // R3
    enter_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_active[g]) |-> $past(cfg_flag && !port_owner[g]));

    // R4
    enter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_active[g]) |-> $past(!per_sched_en && !async_sched_en &&
                                      !per_sched_busy && !async_sched_busy));

    // R7
    reserved_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(g) && wr_data > CODE_W'(5) && !force_exit[g])
        |=> $stable(drive_cmd[CMD_W*g +: CMD_W]));

    // R8
    exit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(g) && wr_data == '0) |=> !test_active[g]);
  end

  ptest_err u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (wr_reject),
    .clear(err_clear),
    .err  (test_err)
  );

  // R5
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(test_active));

  // R6
  reserved_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < ADDR_W'(NUM_PORTS) && wr_data > CODE_W'(5)) |=> test_err);

endmodule

// File: tb/usb_port_test_ctrl_bench.sv
module usb_port_test_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = $clog2(NP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_we = 1'b0;
  logic [AW-1:0] d_addr = '0;
  logic [3:0] d_data = '0;
  logic d_cfg = 1'b0;
  logic [NP-1:0] d_owner = '0;
  logic [3:0] d_sched = '0;
  logic [3*NP-1:0] drive_cmd;
  logic [NP-1:0] test_active;
  logic [NP-1:0] start_pulse;
  logic test_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_port_test_ctrl #(.NUM_PORTS(NP)) u_usb_port_test_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(d_we), .wr_addr(d_addr), .wr_data(d_data),
    .cfg_flag(d_cfg), .port_owner(d_owner),
    .per_sched_en(d_sched[0]), .async_sched_en(d_sched[1]),
    .per_sched_busy(d_sched[2]), .async_sched_busy(d_sched[3]),
    .drive_cmd(drive_cmd), .test_active(test_active),
    .start_pulse(start_pulse), .test_err(test_err)
  );

  typedef struct {
    logic [3*NP-1:0] cmd;
    logic [NP-1:0]   pulse;
    logic            err;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state kept by the bench
  int m_field[NP];
  bit m_err = 1'b0;
  bit b_cfg = 1'b1;
  bit [NP-1:0] b_owner = '0;
  bit [3:0] b_sched = '0;

  task automatic cyc(input bit we, input int addr, input int data, input string tag);
    int nf[NP];
    bit [NP-1:0] pulse;
    bit lost;
    bit busy_other;
    bit ok;
    exp_t e;
    @(negedge clk);
    d_we = we; d_addr = AW'(addr); d_data = 4'(data);
    d_cfg = b_cfg; d_owner = b_owner; d_sched = b_sched;
    pulse = '0;
    for (int p = 0; p < NP; p++) begin
      lost = (m_field[p] != 0) && (!b_cfg || b_owner[p]);
      nf[p] = lost ? 0 : m_field[p];
    end
    if (we && addr < NP) begin
      busy_other = 1'b0;
      for (int p = 0; p < NP; p++)
        if (p != addr && m_field[p] != 0) busy_other = 1'b1;
      ok = (data == 0) ||
           (data <= 5 && b_cfg && !b_owner[addr] && b_sched == 4'd0 && !busy_other);
      if (!ok) m_err = 1'b1;
      else if (!((m_field[addr] != 0) && (!b_cfg || b_owner[addr]))) begin
        if ((data == 4 || data == 5) && data != m_field[addr]) pulse[addr] = 1'b1;
        nf[addr] = data;
      end
    end else if (we && addr == NP && (data % 2) == 1) begin
      m_err = 1'b0;
    end
    for (int p = 0; p < NP; p++) begin
      m_field[p] = nf[p];
      e.cmd[3*p +: 3] = 3'(nf[p]);
    end
    e.pulse = pulse;
    e.err = m_err;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 0, 0, tag);
  endtask

  // monitor: one expected item per clock edge
  always @(posedge clk) begin
    exp_t e;
    logic [NP-1:0] act;
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      for (int p = 0; p < NP; p++) act[p] = |e.cmd[3*p +: 3];
      checks++;
      if (drive_cmd !== e.cmd || start_pulse !== e.pulse ||
          test_err !== e.err || test_active !== act) begin
        failures++;
        $display("FAIL %s: cmd=%h pulse=%b err=%b act=%b expected cmd=%h pulse=%b err=%b act=%b",
                 e.tag, drive_cmd, start_pulse, test_err, test_active,
                 e.cmd, e.pulse, e.err, act);
      end
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) m_field[p] = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    checks++;
    if (drive_cmd !== '0 || test_active !== '0 || start_pulse !== '0 || test_err !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: cmd=%h act=%b pulse=%b err=%b expected all zero",
               drive_cmd, test_active, start_pulse, test_err);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 after reset");

    // R2 each mode on its port, R8 exit
    cyc(1, 0, 1, "R2 port0 J");
    cyc(1, 0, 0, "R8 port0 exit");
    cyc(1, 1, 2, "R2 port1 K");
    cyc(1, 1, 0, "R8 port1 exit");
    cyc(1, 2, 3, "R2 port2 SE0_NAK");
    cyc(1, 2, 0, "R8 port2 exit");
    cyc(1, 3, 4, "R10 port3 packet pulse");
    idle("R10 pulse one cycle");
    cyc(1, 3, 4, "R10 repeated code no pulse");
    cyc(1, 3, 5, "R10 switch to force enable pulse");
    idle("R10 force held");
    cyc(1, 3, 0, "R8 port3 exit");

    // R3 ownership
    b_cfg = 1'b0;
    cyc(1, 1, 1, "R3 configure flag low");
    b_cfg = 1'b1;
    cyc(1, NP, 1, "R7 clear error");
    b_owner = 4'b0100;
    cyc(1, 2, 1, "R3 owner bit set");
    cyc(1, NP, 0, "R7 clear with bit0 zero ignored");
    cyc(1, NP, 1, "R7 clear error");
    b_owner = '0;

    // R4 each schedule bit
    for (int b = 0; b < 4; b++) begin
      b_sched = 4'(1 << b);
      cyc(1, 0, 2, "R4 schedule bit set");
      b_sched = '0;
      cyc(1, NP, 1, "R7 clear error");
    end

    // R6 reserved codes
    cyc(1, 1, 6, "R6 code 6");
    cyc(1, NP, 1, "R7 clear error");
    cyc(1, 1, 15, "R6 code 15");
    cyc(1, NP, 1, "R7 clear error");

    // R5 exclusivity
    cyc(1, 0, 1, "R5 port0 enters J");
    cyc(1, 1, 2, "R5 second port refused");
    cyc(1, 0, 2, "R5 same port switches to K");
    cyc(1, 0, 9, "R7 reserved on active port keeps field");
    cyc(1, 0, 0, "R8 port0 exit");
    cyc(1, 1, 2, "R8 lock released port1 enters");
    cyc(1, NP, 1, "R7 clear error");

    // R9 forced exits
    b_cfg = 1'b0;
    idle("R9 configure flag drop");
    cyc(1, 1, 0, "R8 exit write while unowned no error");
    b_cfg = 1'b1;
    cyc(1, 2, 4, "R10 port2 packet pulse");
    b_owner = 4'b0100;
    idle("R9 owner bit change");
    b_owner = 4'b0001;
    cyc(1, 3, 5, "R10 port3 force pulse");
    cyc(1, 0, 1, "R3 unowned port0 refused");
    b_owner = 4'b1000;
    cyc(1, 3, 5, "R9 forced exit wins over write");
    b_owner = '0;
    cyc(1, NP, 1, "R7 clear error");
    cyc(1, 3, 3, "R2 port3 SE0_NAK");
    b_sched = 4'b0010;
    idle("R4 schedule on after entry keeps mode");
    b_sched = '0;
    cyc(1, 3, 0, "R8 port3 exit");
    idle("final");
    idle("final");
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule